// File: doc/BRIEF.md
# Storage Controller Configuration and Status Register Block

This block holds the control-side registers of a storage controller: a configuration word carrying the enable bit and the shutdown-notification field, a status word, an interrupt mask with separate set and clear addresses, the admin queue size word and two 4 KiB-aligned 64-bit admin queue base addresses. Software reaches them through a simple 32-bit write port and a combinational read port addressed by byte offset.

Each write to the configuration word is compared against the value it replaces. A rising enable sends a one-cycle start request to the controller core and waits for a done strobe carrying pass or fail, which sets either the ready or the fatal status bit. A falling enable resets the controller: configuration, status and all interrupt state are wiped while the queue registers survive. A shutdown request only clears interrupt state and reports shutdown-complete in the status word. One interrupt line is raised whenever a pending interrupt source is not masked.

Top module: `ctrl_cfg_regs`

## Requirements
- R1: A write to offset 0x14 replaces the configuration word with the write data ANDed with 0x00FFFFF1; reads of 0x14 return the stored value. Enable is bit 0 and the shutdown-notification field is bits 15:14.
- R2: Transitions are judged against the configuration value held before the write: writing enable=1 while enable is already 1 issues no start request and leaves the status word unchanged.
- R3: A write that moves enable from 0 to 1 raises start_req for exactly the one cycle after the write; the ready and fatal status bits read 0 until start_done arrives.
- R4: Status is read at 0x1C with ready at bit 0, fatal at bit 1 and shutdown status at bits 3:2. A start_done with start_ok=1 after a start request sets the status to ready (0x1); with start_ok=0 it sets fatal (0x2). A start_done with no start outstanding has no effect.
- R5: A write that moves enable from 1 to 0 clears the configuration word and the status word to zero; the words at 0x24, 0x28, 0x2C, 0x30 and 0x34 keep their contents.
- R6: A controller reset (enable 1 to 0) or a shutdown request clears the interrupt mask and every pending interrupt, so irq_out is low and the mask reads zero afterwards.
- R7: A write that moves the shutdown field from zero to nonzero sets status bits 3:2 to 2'b10 and leaves the configuration write stored and the ready/fatal bits unchanged; a write that moves it from nonzero back to zero sets bits 3:2 to 2'b00.
- R8: A write to 0x0C sets the mask bits written as 1, a write to 0x10 clears them; both offsets read the mask. A high irq_evt bit makes that source pending, and irq_out is high when any pending source has its mask bit at 0.
- R9: A write to 0x24 stores the data ANDed with 0x0FFF0FFF.
- R10: A write to 0x28 (0x30) replaces the whole submission (completion) base with the data with bits 11:0 forced to zero and the upper word cleared; a write to 0x2C (0x34) ORs the data into the upper word. Low words read at 0x28/0x30, upper words at 0x2C/0x34.
- R11: Writes to any other offset, including the status offset 0x1C, change nothing, and reads of unlisted offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from stored state |
| irq_evt | input | NUM_VEC | Per-source interrupt event, one cycle sets pending |
| irq_out | output | 1 | Interrupt line |
| start_req | output | 1 | One-cycle controller start request |
| start_done | input | 1 | Start result strobe |
| start_ok | input | 1 | Start result: 1 pass, 0 fail |

## Verification
The bench builds the block with its defaults: an 8-bit offset, four interrupt sources and 12 alignment bits. With only four sources, every pairing of pending pattern and mask pattern (256 combinations) is swept and the interrupt line compared against the arithmetic OR of pending AND NOT mask. All sixteen pairs of old and new shutdown-field values are swept from reset, and the bench checks the status field each transition should leave. Directed sequences cover the start handshake with pass, fail and a stray done, the reset that spares the queue words, and high-word OR accumulation.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;

    localparam int DW = 32;

    // Byte offsets of the register words
    localparam int OFF_MSET = 'h0C;
    localparam int OFF_MCLR = 'h10;
    localparam int OFF_CC   = 'h14;
    localparam int OFF_CSTS = 'h1C;
    localparam int OFF_AQA  = 'h24;
    localparam int OFF_SQL  = 'h28;
    localparam int OFF_CQL  = 'h30;
    localparam int QSTRIDE  = 8;

    localparam logic [DW-1:0] CC_KEEP  = 32'h00FF_FFF1;
    localparam logic [DW-1:0] AQA_KEEP = 32'h0FFF_0FFF;

    localparam logic [1:0] SHST_NONE = 2'b00;
    localparam logic [1:0] SHST_DONE = 2'b10;

    typedef struct packed {
        logic [27:0] rsvd;
        logic [1:0]  shst;
        logic        fatal;
        logic        rdy;
    } status_t;

    typedef struct packed {
        logic en_up;
        logic en_down;
        logic shn_up;
        logic shn_down;
    } cc_edge_t;

    function automatic logic [DW-1:0] base_low_keep(int align);
        return ~((DW'(1) << align) - DW'(1));
    endfunction

endpackage

// File: rtl/ccr_cc_edge.sv
`timescale 1ns/1ps
module ccr_cc_edge
    import ccr_pkg::*;
(
    input  logic       old_en,
    input  logic [1:0] old_shn,
    input  logic       new_en,
    input  logic [1:0] new_shn,
    output cc_edge_t   edges
);
    always_comb begin
        edges.en_up    = new_en && !old_en;
        edges.en_down  = !new_en && old_en;
        edges.shn_up   = (new_shn != 2'b00) && (old_shn == 2'b00);
        edges.shn_down = (new_shn == 2'b00) && (old_shn != 2'b00);
    end
endmodule

// File: rtl/ccr_queue_regs.sv
`timescale 1ns/1ps
module ccr_queue_regs
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ALIGN  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     aqa,
    output logic [2*DW-1:0]   sq_base,
    output logic [2*DW-1:0]   cq_base
);
    localparam logic [DW-1:0] LOW_KEEP = base_low_keep(ALIGN);

    logic [2*DW-1:0] base_q [2];

    always_ff @(posedge clk) begin
        if (rst)
            aqa <= '0;
        else if (wr_en && wr_addr == ADDR_W'(OFF_AQA))
            aqa <= wr_data & AQA_KEEP;
    end

    for (genvar q = 0; q < 2; q++) begin : g_base
        localparam int LO_OFF = OFF_SQL + q * QSTRIDE;
        localparam int HI_OFF = LO_OFF + 4;

        always_ff @(posedge clk) begin
            if (rst)
                base_q[q] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(LO_OFF))
                base_q[q] <= {{DW{1'b0}}, wr_data & LOW_KEEP};
            else if (wr_en && wr_addr == ADDR_W'(HI_OFF))
                base_q[q] <= base_q[q] | {wr_data, {DW{1'b0}}};
        end

        // R10: base stays aligned through every low and high write
        assert_base_aligned_R10: assert property (@(posedge clk) disable iff (rst)
            base_q[q][ALIGN-1:0] == '0);
    end

    assign sq_base = base_q[0];
    assign cq_base = base_q[1];
endmodule

// File: rtl/ccr_irq_unit.sv
`timescale 1ns/1ps
module ccr_irq_unit #(
    parameter int NV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wipe,
    input  logic          set_w,
    input  logic          clr_w,
    input  logic [NV-1:0] wbits,
    input  logic [NV-1:0] evt,
    output logic [NV-1:0] mask,
    output logic          irq_o
);
    logic [NV-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            mask <= '0;
            pend <= '0;
        end else begin
            if (set_w)
                mask <= mask | wbits;
            else if (clr_w)
                mask <= mask & ~wbits;
            pend <= pend | evt;
        end
    end

    assign irq_o = |(pend & ~mask);

    // R6: a wipe leaves the line low on the following cycle
    assert_wipe_quiets_R6: assert property (@(posedge clk) disable iff (rst)
        wipe |=> !irq_o);

    // R8: a set write leaves every written bit set in the mask
    assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
        (set_w && !wipe) |=> ((mask & $past(wbits)) == $past(wbits)));
endmodule

// File: rtl/ctrl_cfg_regs.sv
`timescale 1ns/1ps
module ctrl_cfg_regs
    import ccr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_VEC = 4,
    parameter int ALIGN   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DW-1:0]      rd_data,
    input  logic [NUM_VEC-1:0] irq_evt,
    output logic               irq_out,
    output logic               start_req,
    input  logic               start_done,
    input  logic               start_ok
);
    logic [DW-1:0]      cc_q, cc_d;
    status_t            st_q, st_d;
    logic               wait_q, wait_d;
    logic               req_d;
    logic               irq_wipe;
    logic               wr_cc;
    cc_edge_t           edges;
    logic [NUM_VEC-1:0] mask;
    logic [DW-1:0]      aqa;
    logic [2*DW-1:0]    sq_base, cq_base;

    assign wr_cc = wr_en && wr_addr == ADDR_W'(OFF_CC);

    ccr_cc_edge u_edge (
        .old_en  (cc_q[0]),
        .old_shn (cc_q[15:14]),
        .new_en  (wr_data[0]),
        .new_shn (wr_data[15:14]),
        .edges   (edges)
    );

    always_comb begin
        cc_d     = cc_q;
        st_d     = st_q;
        wait_d   = wait_q;
        req_d    = 1'b0;
        irq_wipe = 1'b0;
        if (start_done && wait_q) begin
            wait_d     = 1'b0;
            st_d.rdy   = start_ok;
            st_d.fatal = !start_ok;
        end
        if (wr_cc) begin
            cc_d = wr_data & CC_KEEP;
            if (edges.en_up) begin
                req_d      = 1'b1;
                wait_d     = 1'b1;
                st_d.rdy   = 1'b0;
                st_d.fatal = 1'b0;
            end else if (edges.en_down) begin
                cc_d     = '0;
                st_d     = '0;
                wait_d   = 1'b0;
                irq_wipe = 1'b1;
            end
            if (edges.shn_up) begin
                irq_wipe  = 1'b1;
                st_d.shst = SHST_DONE;
            end else if (edges.shn_down) begin
                st_d.shst = SHST_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q      <= '0;
            st_q      <= '0;
            wait_q    <= 1'b0;
            start_req <= 1'b0;
        end else begin
            cc_q      <= cc_d;
            st_q      <= st_d;
            wait_q    <= wait_d;
            start_req <= req_d;
        end
    end

    ccr_irq_unit #(.NV(NUM_VEC)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .wipe  (irq_wipe),
        .set_w (wr_en && wr_addr == ADDR_W'(OFF_MSET)),
        .clr_w (wr_en && wr_addr == ADDR_W'(OFF_MCLR)),
        .wbits (wr_data[NUM_VEC-1:0]),
        .evt   (irq_evt),
        .mask  (mask),
        .irq_o (irq_out)
    );

    ccr_queue_regs #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .aqa     (aqa),
        .sq_base (sq_base),
        .cq_base (cq_base)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFF_MSET) || rd_addr == ADDR_W'(OFF_MCLR))
            rd_data = DW'(mask);
        else if (rd_addr == ADDR_W'(OFF_CC))
            rd_data = cc_q;
        else if (rd_addr == ADDR_W'(OFF_CSTS))
            rd_data = st_q;
        else if (rd_addr == ADDR_W'(OFF_AQA))
            rd_data = aqa;
        else if (rd_addr == ADDR_W'(OFF_SQL))
            rd_data = sq_base[DW-1:0];
        else if (rd_addr == ADDR_W'(OFF_SQL + 4))
            rd_data = sq_base[2*DW-1:DW];
        else if (rd_addr == ADDR_W'(OFF_CQL))
            rd_data = cq_base[DW-1:0];
        else if (rd_addr == ADDR_W'(OFF_CQL + 4))
            rd_data = cq_base[2*DW-1:DW];
    end

    // R3: start request never lasts beyond one cycle
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        start_req |=> !start_req);

    // R3: ready and fatal stay clear while a start result is awaited
    assert_wait_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> (!st_q.rdy && !st_q.fatal));

    // R4: ready and fatal are never reported together
    assert_rdy_fatal_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(st_q.rdy && st_q.fatal));

    // R5: disabling wipes configuration and the ready/fatal bits
    assert_disable_wipes_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_cc && cc_q[0] && !wr_data[0]) |=> (cc_q == '0 && !st_q.rdy && !st_q.fatal));

    // R7: a shutdown request reports completion on the next cycle
    assert_shutdown_done_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_cc && cc_q[15:14] == 2'b00 && wr_data[15:14] != 2'b00) |=> st_q.shst == SHST_DONE);
endmodule

// File: tb/ctrl_cfg_regs_tb.sv
`timescale 1ns/1ps
module ctrl_cfg_regs_tb;
    localparam int AW = 8;
    localparam int NV = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NV-1:0] irq_evt = '0;
    logic          irq_out;
    logic          start_req;
    logic          start_done = 1'b0;
    logic          start_ok = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ctrl_cfg_regs #(.ADDR_W(AW), .NUM_VEC(NV), .ALIGN(12)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_evt(irq_evt), .irq_out(irq_out),
        .start_req(start_req), .start_done(start_done), .start_ok(start_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic done_pulse(input logic ok);
        @(negedge clk); start_done = 1'b1; start_ok = ok;
        @(negedge clk); start_done = 1'b0;
    endtask

    task automatic evt_pulse(input logic [NV-1:0] e);
        @(negedge clk); irq_evt = e;
        @(negedge clk); irq_evt = '0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] shst;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        rdchk("R11 reset cc", 8'h14, 32'h0);
        rdchk("R11 reset csts", 8'h1C, 32'h0);
        rdchk("R11 reset aqa", 8'h24, 32'h0);
        rdchk("R11 reset mask", 8'h0C, 32'h0);
        chk("R8 reset irq", {31'b0, irq_out}, 32'h0);
        chk("R3 reset start_req", {31'b0, start_req}, 32'h0);

        // R1 write mask, R7 shutdown rise/fall
        wr(8'h14, 32'hFFFF_FFFE);
        rdchk("R1 cc masked", 8'h14, 32'h00FF_FFF0);
        rdchk("R7 shst done", 8'h1C, 32'h8);
        wr(8'h14, 32'h0);
        rdchk("R7 shst cleared", 8'h1C, 32'h0);

        // R3 start handshake, R4 pass
        wr(8'h14, 32'h1);
        chk("R3 start_req high", {31'b0, start_req}, 32'h1);
        rdchk("R3 csts waits", 8'h1C, 32'h0);
        @(negedge clk);
        chk("R3 start_req one cycle", {31'b0, start_req}, 32'h0);
        repeat (3) @(negedge clk);
        rdchk("R3 csts still waits", 8'h1C, 32'h0);
        done_pulse(1'b1);
        rdchk("R4 ready", 8'h1C, 32'h1);

        // R2 no transition on repeated enable
        wr(8'h14, 32'h1);
        chk("R2 no start", {31'b0, start_req}, 32'h0);
        rdchk("R2 csts kept", 8'h1C, 32'h1);

        // R9, R10 queue words
        wr(8'h24, 32'hFFFF_FFFF);
        rdchk("R9 aqa", 8'h24, 32'h0FFF_0FFF);
        wr(8'h28, 32'h1234_5FFF);
        rdchk("R10 sq low", 8'h28, 32'h1234_5000);
        rdchk("R10 sq high", 8'h2C, 32'h0);
        wr(8'h2C, 32'hA5A5_A5A5);
        wr(8'h2C, 32'h5A5A_5A5A);
        rdchk("R10 sq high OR", 8'h2C, 32'hFFFF_FFFF);
        wr(8'h28, 32'h0000_2000);
        rdchk("R10 sq low replace", 8'h28, 32'h0000_2000);
        rdchk("R10 sq high cleared", 8'h2C, 32'h0);
        wr(8'h2C, 32'h0000_0007);
        wr(8'h30, 32'hDEAD_BEEF);
        wr(8'h34, 32'h0000_0001);
        rdchk("R10 cq low", 8'h30, 32'hDEAD_B000);
        rdchk("R10 cq high", 8'h34, 32'h1);

        // R8 pending unmasked
        evt_pulse(4'h5);
        chk("R8 irq raised", {31'b0, irq_out}, 32'h1);

        // R5, R6 controller reset
        wr(8'h14, 32'h0);
        rdchk("R5 cc wiped", 8'h14, 32'h0);
        rdchk("R5 csts wiped", 8'h1C, 32'h0);
        chk("R6 irq low after reset", {31'b0, irq_out}, 32'h0);
        rdchk("R6 mask wiped", 8'h10, 32'h0);
        rdchk("R5 aqa kept", 8'h24, 32'h0FFF_0FFF);
        rdchk("R5 sq low kept", 8'h28, 32'h0000_2000);
        rdchk("R5 sq high kept", 8'h2C, 32'h7);
        rdchk("R5 cq low kept", 8'h30, 32'hDEAD_B000);
        rdchk("R5 cq high kept", 8'h34, 32'h1);
        wr(8'h0C, 32'h0);
        chk("R6 pending gone", {31'b0, irq_out}, 32'h0);

        // R4 fail path and stray done
        wr(8'h14, 32'h1);
        done_pulse(1'b0);
        rdchk("R4 fatal", 8'h1C, 32'h2);
        done_pulse(1'b1);
        rdchk("R4 stray done ignored", 8'h1C, 32'h2);

        // R6, R7 shutdown with enable held
        evt_pulse(4'h3);
        wr(8'h0C, 32'h4);
        chk("R8 irq before shutdown", {31'b0, irq_out}, 32'h1);
        wr(8'h14, 32'h4001);
        rdchk("R7 shutdown keeps fatal", 8'h1C, 32'hA);
        rdchk("R7 cc stored", 8'h14, 32'h4001);
        chk("R6 irq low after shutdown", {31'b0, irq_out}, 32'h0);
        rdchk("R6 mask cleared by shutdown", 8'h0C, 32'h0);
        wr(8'h14, 32'h1);
        rdchk("R7 shst back to none", 8'h1C, 32'h2);

        // R11 ignored offsets
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        rdchk("R11 csts write ignored", 8'h1C, 32'h2);
        rdchk("R11 cc untouched", 8'h14, 32'h1);
        rdchk("R11 unlisted read 0x38", 8'h38, 32'h0);
        rdchk("R11 unlisted read 0x18", 8'h18, 32'h0);
        rdchk("R11 unlisted read 0x00", 8'h00, 32'h0);

        // R7 sweep over all old/new shutdown field pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset();
                wr(8'h14, 32'(a) << 14);
                shst = (a != 0) ? 2'b10 : 2'b00;
                if (a == 0 && b != 0) shst = 2'b10;
                else if (a != 0 && b == 0) shst = 2'b00;
                wr(8'h14, 32'(b) << 14);
                rdchk($sformatf("R7 sweep %0d->%0d", a, b), 8'h1C, {28'b0, shst, 2'b00});
            end
        end

        // R8 sweep over pending and mask patterns
        for (int p = 0; p < 16; p++) begin
            do_reset();
            evt_pulse(NV'(p));
            for (int m = 0; m < 16; m++) begin
                wr(8'h10, 32'hF);
                wr(8'h0C, 32'(m));
                chk($sformatf("R8 irq p=%0d m=%0d", p, m), {31'b0, irq_out},
                    {31'b0, |(NV'(p) & ~NV'(m))});
            end
        end
        wr(8'h0C, 32'hF);
        wr(8'h10, 32'h5);
        rdchk("R8 partial clear", 8'h10, 32'hA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule